// File: doc/BRIEF.md
# Pipeline ADC Digital Error Correction

This block turns the raw comparator decisions of a twelve-bit pipelined converter into finished output words. The converter has ten stages. The front stage resolves a seven-level code. Each of the nine later stages resolves a redundant three-level code. A single back-end comparator bit ends the chain. Each stage passes its residue on to the next stage, so one sample's decisions reach the block spread over consecutive beats. The front-stage code arrives first, and the back-end bit arrives ten beats later.

The block holds every stage code in a delay line whose length matches how early that code arrives. All decisions of one sample are then presented together. The block adds them with overlapping binary weights, one bit of overlap per stage. Because of this overlap, a comparator that trips slightly early or late still produces the correct word: the next stage corrects the error through its own code. The corrected word leaves through a register with a valid/ready handshake.

The input side also follows valid/ready. A beat is taken only on a cycle where `in_valid` and `in_ready` are both high. While the output word is held and not taken (`out_valid` high, `out_ready` low), `in_ready` drops and the whole alignment freezes. Upstream must then hold its beat unchanged. Beats with `in_valid` low do not advance the alignment either. A stall or a gap therefore never mixes decisions from different samples.

Top module: `pipe_adc_corrector`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: After reset, `out_valid` first goes high on the cycle after the 11th accepted beat. No word is presented before that.
- R3: Each beat carries the decisions of different samples. The beat that carries sample s's front code (`in_first`) carries stage k's code for sample s−k, for k = 1..9. It carries the back-end bit (`in_back`) for sample s−10. Stage k's 2-bit code sits at bits [2(k−1)+1 : 2(k−1)] of `in_red`.
- R4: The output word is: front code × 512, plus the sum over k = 1..9 of (stage k code × 2^(9−k)), plus the back-end bit. Front codes 0..6 (3-bit) and stage codes 0..2 (2-bit: 00, 01, 10) are the legal values.
- R5: All-zero codes give 0. The largest legal codes (front 6, every stage 2, back-end 1) give 4095. Front code 4 with all else 0 gives 2048.
- R6: Different code sets of equal weighted value give the same word. For example, stage 1 = 2, or stage 1 = 1 with stage 2 = 2, or front = 1, all give 512.
- R7: Illegal codes (front 7, stage code 11) are added at their face value. A sum above 4095 is output as 4095.
- R8: While `out_valid` is high and `out_ready` low, `out_data` holds its value, `out_valid` stays high, and `in_ready` is 0.
- R9: Beats not accepted (a gap or back-pressure) leave the alignment untouched. Words come out in sample order with the values of R4.
- R10: With `in_valid` and `out_ready` held high, one word comes out every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat of stage decisions present |
| in_ready | output | 1 | Block takes the beat this cycle |
| in_first | input | 3 | Front-stage seven-level code |
| in_red | input | 18 | Nine 2-bit redundant stage codes, stage 1 in the low bits |
| in_back | input | 1 | Back-end comparator bit |
| out_valid | output | 1 | Corrected word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 12 | Corrected output word |

## Verification
The bench builds the block with its default of nine redundant stages. This gives a twelve-bit word and delay lines from ten beats deep down to one. Per-stage one-hot codes, the legal extremes and equal-valued redundant code sets exercise every weight and the overlap. Illegal face values push the raw sum past the top of the twelve-bit range, which exercises the clamp. Periodic input gaps and output stalls test that the staggered delay lines stay aligned with each other.

// File: rtl/pac_pkg.sv
package pac_pkg;
  // width of a redundant three-level stage code
  localparam int RED_W   = 2;
  // width of the seven-level front-stage code
  localparam int FIRST_W = 3;
endpackage

// File: rtl/pac_delay.sv
module pac_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else if (adv) begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign dout = sr[DEPTH-1];

  // R9
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(dout));
endmodule

// File: rtl/pac_sum.sv
module pac_sum import pac_pkg::*; #(
  parameter int NSTG = 9,
  localparam int OUT_W = NSTG + 3,
  localparam int SUM_W = OUT_W + 1
) (
  input  logic [FIRST_W-1:0]    first,
  input  logic [NSTG*RED_W-1:0] red,
  input  logic                  back,
  output logic [OUT_W-1:0]      word
);
  localparam logic [SUM_W-1:0] TOP = SUM_W'((1 << OUT_W) - 1);

  logic [SUM_W-1:0] acc;

  always_comb begin
    acc = SUM_W'(first) << NSTG;
    for (int k = 1; k <= NSTG; k++)
      acc = acc + (SUM_W'(red[(k-1)*RED_W +: RED_W]) << (NSTG - k));
    acc = acc + SUM_W'(back);
  end

  assign word = (acc > TOP) ? '1 : acc[OUT_W-1:0];
endmodule

// File: rtl/pac_emit.sv
module pac_emit #(
  parameter int OUT_W = 12,
  parameter int FILL  = 10,
  localparam int CNT_W = $clog2(FILL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [OUT_W-1:0] word,
  output logic             in_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign full     = (cnt == CNT_W'(FILL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (accept && !full) cnt <= cnt + 1'b1;
      if (accept && full) begin
        out_valid <= 1'b1;
        out_data  <= word;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  no_early_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !out_valid);

  // R10
  rise_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept));
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector import pac_pkg::*; #(
  parameter int NSTG = 9,
  localparam int OUT_W = NSTG + 3,
  localparam int LAST  = NSTG + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [FIRST_W-1:0]    in_first,
  input  logic [NSTG*RED_W-1:0] in_red,
  input  logic                  in_back,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [OUT_W-1:0]      out_data
);
  logic                  adv;
  logic [FIRST_W-1:0]    al_first;
  logic [NSTG*RED_W-1:0] al_red;
  logic                  al_back;
  logic [OUT_W-1:0]      word;

  assign adv     = in_valid && in_ready;
  assign al_back = in_back;

  // front code arrives earliest, so it waits longest
  pac_delay #(.W(FIRST_W), .DEPTH(LAST)) u_dly_first (
    .clk(clk), .rst_n(rst_n), .adv(adv), .din(in_first), .dout(al_first));

  for (genvar k = 1; k <= NSTG; k++) begin : g_red
    pac_delay #(.W(RED_W), .DEPTH(LAST - k)) u_dly (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .din(in_red[(k-1)*RED_W +: RED_W]),
      .dout(al_red[(k-1)*RED_W +: RED_W]));
  end

  pac_sum #(.NSTG(NSTG)) u_sum (
    .first(al_first), .red(al_red), .back(al_back), .word(word));

  pac_emit #(.OUT_W(OUT_W), .FILL(LAST)) u_emit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .word(word), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data));

  // R1
  ready_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: tb/sim_pipe_adc_corrector.sv
module sim_pipe_adc_corrector;
  localparam int NSTG = 9;
  localparam int LAST = NSTG + 1;
  localparam int MAXN = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n, in_valid, in_ready, in_back, out_valid, out_ready;
  logic [2:0]        in_first;
  logic [NSTG*2-1:0] in_red;
  logic [11:0]       out_data;

  pipe_adc_corrector #(.NSTG(NSTG)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_red(in_red), .in_back(in_back),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int total = 0, bad = 0;
  bit done = 0;
  logic [2:0] s_first [MAXN];
  logic [1:0] s_red   [MAXN][NSTG+1];
  logic       s_back  [MAXN];
  int         got     [MAXN];
  int nsmp, beat, ocnt, acc_cnt, cyc_no, first_out, last_out;
  bit seen_out, prev_stall;
  logic [11:0] prev_data;

  function automatic int expect_word(int i);
    int v;
    v = int'(s_first[i]) << NSTG;
    for (int k = 1; k <= NSTG; k++) v += int'(s_red[i][k]) << (NSTG - k);
    v += int'(s_back[i]);
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_smp();
    for (int i = 0; i < MAXN; i++) begin
      s_first[i] = 0; s_back[i] = 0; got[i] = -1;
      for (int k = 0; k <= NSTG; k++) s_red[i][k] = 0;
    end
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; out_ready = 0;
    in_first = 0; in_red = '0; in_back = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    beat = 0; ocnt = 0; acc_cnt = 0; cyc_no = 0;
    seen_out = 0; prev_stall = 0; first_out = 0; last_out = 0;
  endtask

  task automatic drive_beat();
    int idx;
    in_first = (beat >= 0 && beat < nsmp) ? s_first[beat] : 3'd0;
    for (int k = 1; k <= NSTG; k++) begin
      idx = beat - k;
      in_red[(k-1)*2 +: 2] = (idx >= 0 && idx < nsmp) ? s_red[idx][k] : 2'd0;
    end
    idx = beat - LAST;
    in_back = (idx >= 0 && idx < nsmp) ? s_back[idx] : 1'b0;
  endtask

  task automatic cyc(bit iv, bit ordy, string tag);
    drive_beat();
    in_valid = iv; out_ready = ordy;
    #1;
    cyc_no++;
    if (prev_stall) begin
      check(out_valid == 1'b1, "R8", out_valid, 1);
      check(out_data == prev_data, "R8", out_data, prev_data);
    end
    if (out_valid && !seen_out) begin
      seen_out = 1; first_out = cyc_no;
      check(acc_cnt == LAST + 1, "R2", acc_cnt, LAST + 1);
    end
    if (out_valid && out_ready) begin
      if (ocnt < nsmp) begin
        got[ocnt] = out_data;
        check(out_data == expect_word(ocnt), tag, out_data, expect_word(ocnt));
      end
      ocnt++; last_out = cyc_no;
    end
    if (out_valid && !out_ready) check(in_ready == 1'b0, "R8", in_ready, 0);
    prev_stall = out_valid && !out_ready;
    prev_data = out_data;
    if (iv && in_ready) begin beat++; acc_cnt++; end
    @(negedge clk);
  endtask

  task automatic run_stream(string tag, bit gaps, bit bp);
    int i = 0;
    do_reset();
    while (ocnt < nsmp && i < 3000) begin
      cyc(gaps ? (i % 3 != 1) : 1'b1, bp ? (i % 4 < 2) : 1'b1, tag);
      i++;
    end
    check(ocnt >= nsmp, tag, ocnt, nsmp);
  endtask

  task automatic fill_mixed(int n, int seed);
    clear_smp();
    nsmp = n;
    for (int i = 0; i < n; i++) begin
      s_first[i] = 3'((i * 5 + seed) % 7);
      for (int k = 1; k <= NSTG; k++) s_red[i][k] = 2'((i + 2 * k + seed) % 3);
      s_back[i] = 1'((i + seed) % 2);
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);
  endtask

  task automatic t_weights();
    clear_smp();
    nsmp = 14;
    s_first[1] = 1;
    for (int k = 1; k <= NSTG; k++) s_red[k+1][k] = 1;
    s_back[11] = 1;
    s_first[12] = 6; s_back[12] = 1;
    for (int k = 1; k <= NSTG; k++) s_red[12][k] = 2;
    s_first[13] = 4;
    run_stream("R4", 0, 0);
    check(got[0] == 0, "R5", got[0], 0);
    check(got[12] == 4095, "R5", got[12], 4095);
    check(got[13] == 2048, "R5", got[13], 2048);
    check(got[2] == 256, "R4", got[2], 256);
    check(got[11] == 1, "R4", got[11], 1);
  endtask

  task automatic t_align();
    fill_mixed(24, 3);
    run_stream("R3", 0, 0);
  endtask

  task automatic t_redund();
    clear_smp();
    nsmp = 3;
    s_red[0][1] = 2;
    s_red[1][1] = 1; s_red[1][2] = 2;
    s_first[2] = 1;
    run_stream("R6", 0, 0);
    for (int i = 0; i < 3; i++) check(got[i] == 512, "R6", got[i], 512);
  endtask

  task automatic t_illegal();
    clear_smp();
    nsmp = 4;
    s_first[0] = 7;
    for (int k = 1; k <= NSTG; k++) s_red[0][k] = 3;
    s_back[0] = 1;
    s_first[1] = 7;
    s_first[2] = 6; s_red[2][1] = 3;
    s_first[3] = 7; s_red[3][1] = 3; s_red[3][2] = 3;
    run_stream("R7", 0, 0);
    check(got[0] == 4095, "R7", got[0], 4095);
    check(got[1] == 3584, "R7", got[1], 3584);
    check(got[2] == 3840, "R7", got[2], 3840);
    check(got[3] == 4095, "R7", got[3], 4095);
  endtask

  task automatic t_backpr();
    fill_mixed(30, 1);
    run_stream("R9", 1, 1);
    fill_mixed(20, 5);
    run_stream("R8", 0, 1);
  endtask

  task automatic t_rate();
    fill_mixed(20, 2);
    run_stream("R10", 0, 0);
    check(last_out - first_out == nsmp - 1, "R10", last_out - first_out, nsmp - 1);
  endtask

  initial begin
    t_reset();
    t_weights();
    t_align();
    t_redund();
    t_illegal();
    t_backpr();
    t_rate();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule